// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A four-wire style interface (test clock, mode select, serial data in, serial data out with an enable) walks a sixteen-state controller. The controller routes exactly one shift register at a time between the serial input and the serial output. The registers are a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a parameterised chain of boundary cells. There is no dedicated port-reset pin. The controller returns to its reset state after power-on reset or after mode select has been held high for five rising test-clock edges. Entering that state always reloads the identification instruction.

Mode select and serial data are sampled on the rising test-clock edge. Serial out and its enable are registered on the falling edge. The boundary chain captures the device's parallel inputs (`sys_in`) and shifts them out. At Update-DR it transfers the shifted-in data into a parallel update stage (`bsr_out`). `bsr_drive` marks when the external-test instruction is active, so surrounding logic may drive pins from the update stage.

Controller states: Reset, Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. The transitions below are listed as mode select = 1 / mode select = 0. Reset goes to Reset / Idle. Idle goes to Select-DR / Idle. Select-DR goes to Select-IR / Capture-DR, and Select-IR goes to Reset / Capture-IR. Each Capture and each Shift state goes to its Exit1 / Shift. Exit1 goes to Update / Pause, and Pause goes to Exit2 / Pause. Exit2 goes to Update / Shift. Each Update state goes to Select-DR / Idle.

Top module: `scan_port`

## Requirements
- R1: After power-on reset the port is inert: the serial output enable is 0, the serial output is 0, `bsr_out` is all zero and `bsr_drive` is 0. A data scan made without first loading an instruction returns the identification value.
- R2: Five consecutive rising test-clock edges with mode select high bring the controller to Reset from any state, including Shift-DR and Pause-IR.
- R3: Whenever the controller is in Reset, the active instruction becomes 001 (identification).
- R4: In Capture-IR the instruction shift register loads 001, which shifts out as 1, 0, 0. A newly shifted instruction takes effect only at Update-IR and not earlier, for example not in Exit1-IR.
- R5: With instruction 001, Shift-DR presents the 32-bit `ID_VALUE` least significant bit first, and that bit is 1.
- R6: Instructions 011, 100, 101, 110 and 111 select the 1-bit bypass register. It captures 0, so a data scan returns 0 followed by the input bits delayed by one position.
- R7: The serial output enable is 1 only while the controller is in Shift-IR or Shift-DR, and the serial output is 0 while it is disabled. Both change on the falling test-clock edge, never on the rising edge.
- R8: With instruction 010 (sample/preload), Capture-DR loads `sys_in` into the chain. It shifts out with bit 0 first. At Update-DR the shifted-in bits are copied to `bsr_out`, bit k being the k-th bit shifted in.
- R9: `bsr_drive` is 1 exactly when the active instruction is 000 (external test). That instruction uses the same boundary chain as 010.
- R10: While mode select stays high, the serial data input has no effect: the controller remains in Reset, the output stays disabled and `bsr_out` is unchanged.
- R11: Leaving Shift-DR through Exit1-DR, Pause-DR and Exit2-DR back into Shift-DR continues the scan without a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| sys_in | input | BSR_LEN | Parallel values captured by the boundary chain |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Serial output enable |
| bsr_out | output | BSR_LEN | Boundary update stage |
| bsr_drive | output | 1 | External-test instruction active |

## Verification
All eight opcodes are loaded in turn, and each is followed by a data scan of a length that separates the three data registers. A 32-bit identification read, a one-bit-delayed bypass read and a boundary read that echoes `sys_in` cannot be mistaken for one another. All 256 boundary input values are swept under sample/preload, each with a distinct shifted-in pattern, so capture errors are separated from update errors. Five-high resets are applied from the middle of a data shift and from Pause-IR. A paused identification scan, plus probes taken between the rising and falling edges, separate state-sequence faults from output-timing faults.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_LEN = 3;

    localparam logic [IR_LEN-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_LEN-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_LEN-1:0] OP_SAMPLE  = 3'b010;
    localparam logic [IR_LEN-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        S_RESET  = 4'd0,
        S_IDLE   = 4'd1,
        S_SEL_DR = 4'd2,
        S_CAP_DR = 4'd3,
        S_SH_DR  = 4'd4,
        S_EX1_DR = 4'd5,
        S_PAU_DR = 4'd6,
        S_EX2_DR = 4'd7,
        S_UPD_DR = 4'd8,
        S_SEL_IR = 4'd9,
        S_CAP_IR = 4'd10,
        S_SH_IR  = 4'd11,
        S_EX1_IR = 4'd12,
        S_PAU_IR = 4'd13,
        S_EX2_IR = 4'd14,
        S_UPD_IR = 4'd15
    } tap_state_e;

    typedef struct packed {
        logic in_reset;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
    } tap_ctl_t;

    typedef enum logic [1:0] {
        DR_BYP = 2'd0,
        DR_ID  = 2'd1,
        DR_BSR = 2'd2
    } dr_sel_e;

    function automatic dr_sel_e pick_dr(input logic [IR_LEN-1:0] op);
        dr_sel_e r;
        case (op)
            OP_EXTEST, OP_SAMPLE: r = DR_BSR;
            OP_IDCODE:            r = DR_ID;
            default:              r = DR_BYP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_ctl_t   ctl
);

    tap_state_e state_d;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state_q <= S_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RESET:  state_d = tms ? S_RESET  : S_IDLE;
            S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: state_d = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: state_d = tms ? S_SEL_DR : S_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            S_RESET:  ctl.in_reset = 1'b1;
            S_CAP_IR: ctl.cap_ir   = 1'b1;
            S_SH_IR:  ctl.sh_ir    = 1'b1;
            S_UPD_IR: ctl.upd_ir   = 1'b1;
            S_CAP_DR: ctl.cap_dr   = 1'b1;
            S_SH_DR:  ctl.sh_dr    = 1'b1;
            S_UPD_DR: ctl.upd_dr   = 1'b1;
            default:  ctl          = '0;
        endcase
    end

    // Run of consecutive high mode-select edges, saturating at five
    logic [2:0] hi_cnt;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)              hi_cnt <= 3'd0;
        else if (!tms)           hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
        (hi_cnt == 3'd5) |-> (state_q == S_RESET));

endmodule

// File: rtl/scan_instr_reg.sv
module scan_instr_reg
    import scan_pkg::*;
(
    input  logic              tck,
    input  logic              por_n,
    input  logic              tdi,
    input  logic              in_reset,
    input  logic              cap_ir,
    input  logic              sh_ir,
    input  logic              upd_ir,
    output logic [IR_LEN-1:0] ir_q,
    output logic              ir_lsb
);

    logic [IR_LEN-1:0] ir_sh;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      ir_sh <= '0;
        else if (cap_ir) ir_sh <= IR_CAPTURE;
        else if (sh_ir)  ir_sh <= {tdi, ir_sh[IR_LEN-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)        ir_q <= OP_IDCODE;
        else if (in_reset) ir_q <= OP_IDCODE;
        else if (upd_ir)   ir_q <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

    a_r3_reset_loads_idcode: assert property (@(posedge tck) disable iff (!por_n)
        in_reset |=> (ir_q == OP_IDCODE));

    a_r4_ir_holds_outside_update: assert property (@(posedge tck) disable iff (!por_n)
        (!upd_ir && !in_reset) |=> $stable(ir_q));

endmodule

// File: rtl/scan_data_regs.sv
module scan_data_regs
    import scan_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h2B7D_0E3F
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  logic               cap_dr,
    input  logic               sh_dr,
    input  logic               upd_dr,
    input  dr_sel_e            sel,
    input  logic [BSR_LEN-1:0] sys_in,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               dr_lsb
);

    localparam int ID_LEN = 32;

    logic sel_byp, sel_id, sel_bsr;
    assign sel_byp = (sel == DR_BYP);
    assign sel_id  = (sel == DR_ID);
    assign sel_bsr = (sel == DR_BSR);

    // Bypass: one cell, captures zero
    logic byp_q;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)                 byp_q <= 1'b0;
        else if (cap_dr && sel_byp) byp_q <= 1'b0;
        else if (sh_dr && sel_byp)  byp_q <= tdi;
    end

    // Identification register
    logic [ID_LEN-1:0] id_sh;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)                id_sh <= '0;
        else if (cap_dr && sel_id) id_sh <= ID_VALUE;
        else if (sh_dr && sel_id)  id_sh <= {tdi, id_sh[ID_LEN-1:1]};
    end

    // Boundary chain, one generated cell per bit
    logic [BSR_LEN-1:0] bsr_sh;
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        logic chain_in;
        logic cap_q;
        logic upd_q;
        if (i == BSR_LEN - 1) begin : g_head
            assign chain_in = tdi;
        end else begin : g_link
            assign chain_in = bsr_sh[i+1];
        end
        always_ff @(posedge tck or negedge por_n) begin
            if (!por_n)                 cap_q <= 1'b0;
            else if (cap_dr && sel_bsr) cap_q <= sys_in[i];
            else if (sh_dr && sel_bsr)  cap_q <= chain_in;
        end
        always_ff @(posedge tck or negedge por_n) begin
            if (!por_n)                 upd_q <= 1'b0;
            else if (upd_dr && sel_bsr) upd_q <= cap_q;
        end
        assign bsr_sh[i]  = cap_q;
        assign bsr_out[i] = upd_q;
    end

    always_comb begin
        unique case (sel)
            DR_ID:   dr_lsb = id_sh[0];
            DR_BSR:  dr_lsb = bsr_sh[0];
            default: dr_lsb = byp_q;
        endcase
    end

    a_r6_single_register: assert property (@(posedge tck) disable iff (!por_n)
        $onehot({sel_byp, sel_id, sel_bsr}));

    a_r6_bypass_one_delay: assert property (@(posedge tck) disable iff (!por_n)
        (sh_dr && sel_byp) |=> (byp_q == $past(tdi)));

    a_r5_id_capture: assert property (@(posedge tck) disable iff (!por_n)
        (cap_dr && sel_id) |=> (id_sh == ID_VALUE));

    a_r8_update_only_at_update_dr: assert property (@(posedge tck) disable iff (!por_n)
        !(upd_dr && sel_bsr) |=> $stable(bsr_out));

endmodule

// File: rtl/scan_port.sv
module scan_port
    import scan_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h2B7D_0E3F
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] sys_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               bsr_drive
);

    tap_state_e        state_q;
    tap_ctl_t          ctl;
    logic [IR_LEN-1:0] ir_q;
    logic              ir_lsb;
    logic              dr_lsb;
    dr_sel_e           sel;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_q (state_q),
        .ctl     (ctl)
    );

    scan_instr_reg u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .in_reset (ctl.in_reset),
        .cap_ir   (ctl.cap_ir),
        .sh_ir    (ctl.sh_ir),
        .upd_ir   (ctl.upd_ir),
        .ir_q     (ir_q),
        .ir_lsb   (ir_lsb)
    );

    assign sel       = pick_dr(ir_q);
    assign bsr_drive = (ir_q == OP_EXTEST);

    scan_data_regs #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .cap_dr  (ctl.cap_dr),
        .sh_dr   (ctl.sh_dr),
        .upd_dr  (ctl.upd_dr),
        .sel     (sel),
        .sys_in  (sys_in),
        .bsr_out (bsr_out),
        .dr_lsb  (dr_lsb)
    );

    logic serial_bit;
    logic shifting;
    assign shifting   = ctl.sh_ir || ctl.sh_dr;
    assign serial_bit = ctl.sh_ir ? ir_lsb : (ctl.sh_dr ? dr_lsb : 1'b0);

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= serial_bit;
            tdo_oe <= shifting;
        end
    end

    a_r7_oe_only_in_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state_q == S_SH_IR || state_q == S_SH_DR));

    a_r7_low_when_disabled: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_oe |-> !tdo);

    a_r9_drive_follows_update: assert property (@(posedge tck) disable iff (!por_n)
        $rose(bsr_drive) |-> $past(state_q == S_UPD_IR));

endmodule

// File: tb/sim_scan_port.sv
`timescale 1ns/1ps
module sim_scan_port;

    localparam int          BSR_LEN = 8;
    localparam logic [31:0] ID_VAL  = 32'h2B7D_0E3F;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic [BSR_LEN-1:0] sys_in = '0;
    logic tdo, tdo_oe, bsr_drive;
    logic [BSR_LEN-1:0] bsr_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 tck = ~tck;

    scan_port #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VAL)) u0 (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .sys_in(sys_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .bsr_out(bsr_out), .bsr_drive(bsr_drive)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs, pass one rising and one falling edge, settle
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // From Idle: load an instruction, return to Idle; cap = bits seen on tdo
    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cap[k] = tdo;
            step(k == 2, code[k]);
        end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        dout = '0;
        for (int k = 0; k < len; k++) begin
            dout[k] = tdo;
            step(k == len - 1, din[k]);
        end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
    endtask

    bit done = 0;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [63:0] exp;
        logic [7:0]  pat;

        #9 por_n = 1'b1;
        @(negedge tck); #1;
        // R1: reset state
        chk(tdo_oe == 1'b0 && tdo == 1'b0, "R1 tdo after reset", {tdo_oe, tdo}, 0);
        chk(bsr_out == '0, "R1 bsr_out after reset", bsr_out, 0);
        chk(bsr_drive == 1'b0, "R1 bsr_drive after reset", bsr_drive, 0);
        step(1'b0, 1'b0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_VAL, "R1 R5 id without ir load", dout[31:0], ID_VAL);
        chk(dout[0] == 1'b1, "R5 id lsb", dout[0], 1);

        // Sweep of all opcodes
        for (int op = 0; op < 8; op++) begin
            scan_ir(op[2:0], cap);
            chk(cap == 3'b001, "R4 ir capture", cap, 3'b001);
            chk(bsr_drive == (op == 0), "R9 bsr_drive per opcode", bsr_drive, (op == 0));
            if (op == 1) begin
                scan_dr(32, 64'hFFFF_0000, dout);
                chk(dout[31:0] == ID_VAL, "R5 id read", dout[31:0], ID_VAL);
            end else if (op == 0 || op == 2) begin
                sys_in = 8'h5A ^ 8'(op * 37);
                pat = ~sys_in ^ 8'h0F;
                scan_dr(BSR_LEN, {56'h0, pat}, dout);
                chk(dout[7:0] == sys_in, op == 0 ? "R9 extest capture" : "R8 sample capture", dout[7:0], sys_in);
                chk(bsr_out == pat, op == 0 ? "R9 extest update" : "R8 preload update", bsr_out, pat);
            end else begin
                pat = 8'hC3 ^ 8'(op * 29);
                scan_dr(8, {56'h0, pat}, dout);
                exp = {56'h0, pat[6:0], 1'b0};
                chk(dout == exp, "R6 bypass one delay", dout, exp);
            end
        end

        // R8: exhaustive boundary sweep under sample/preload
        scan_ir(3'b010, cap);
        for (int v = 0; v < 256; v++) begin
            sys_in = 8'(v);
            pat = 8'(v) ^ 8'h3C;
            scan_dr(BSR_LEN, {56'h0, pat}, dout);
            chk(dout[7:0] == 8'(v), "R8 sweep capture", dout[7:0], v);
            chk(bsr_out == pat, "R8 sweep update", bsr_out, pat);
        end

        // R4: new instruction not active before Update-IR
        to_idle();
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        chk(bsr_drive == 1'b0, "R4 not active in Exit1-IR", bsr_drive, 0);
        step(1'b1, 1'b0);
        chk(bsr_drive == 1'b0, "R4 not active during Update-IR entry", bsr_drive, 0);
        step(1'b0, 1'b0);
        chk(bsr_drive == 1'b1, "R4 R9 active after Update-IR", bsr_drive, 1);

        // R2/R3: five-high reset from mid Shift-DR
        scan_ir(3'b111, cap);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk(tdo_oe == 1'b1, "R7 enabled in Shift-DR", tdo_oe, 1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk(tdo_oe == 1'b0, "R2 disabled after five high", tdo_oe, 0);
        step(1'b0, 1'b0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_VAL, "R2 R3 id after reset from Shift-DR", dout[31:0], ID_VAL);

        // R2: from Pause-IR
        scan_ir(3'b100, cap);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_VAL, "R2 R3 id after reset from Pause-IR", dout[31:0], ID_VAL);

        // R11: paused identification scan
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        dout = '0;
        for (int k = 0; k < 10; k++) begin
            dout[k] = tdo;
            step(k == 9, 1'b0);
        end
        step(1'b0, 1'b0);
        chk(tdo_oe == 1'b0 && tdo == 1'b0, "R7 disabled in Pause-DR", {tdo_oe, tdo}, 0);
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        for (int k = 10; k < 32; k++) begin
            dout[k] = tdo;
            step(k == 31, 1'b0);
        end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        chk(dout[31:0] == ID_VAL, "R11 pause keeps scan", dout[31:0], ID_VAL);

        // R7: enable changes at falling edge only
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        tms = 1'b0;
        @(posedge tck); #0.5;
        chk(tdo_oe == 1'b0, "R7 no change at rising edge", tdo_oe, 0);
        @(negedge tck); #0.5;
        chk(tdo_oe == 1'b1 && tdo == ID_VAL[0], "R7 change at falling edge", {tdo_oe, tdo}, {1'b1, ID_VAL[0]});

        // R10: inert with mode select held high
        por_n = 1'b0; #3; por_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, i[0]);
            chk(tdo_oe == 1'b0, "R10 inert output", tdo_oe, 0);
        end
        chk(bsr_out == '0, "R10 bsr_out unchanged", bsr_out, 0);
        step(1'b0, 1'b0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_VAL, "R10 R1 id after inert period", dout[31:0], ID_VAL);

        done = 1;
        finish_run();
    end

endmodule